// File: doc/BRIEF.md
# Paged Indirect Operand Address Unit

This block forms operand addresses for a 12-bit word machine whose memory is split into eight fields of 4096 words each. A memory-reference instruction carries a 7-bit offset, a page bit and an indirect bit. The offset and page bit make a 12-bit address inside the instruction field. The page bit picks either page zero or the page that holds the program counter. When the indirect bit is clear, that address is the result. When it is set, the word stored there is fetched and used as a full 12-bit pointer inside the data field.

Two 3-bit field registers, one for instructions and one for data, are loaded by a field-select command. Only the final operand of an indirect access uses the data field, so the data field is the sole route to words outside the instruction field. A direct access finishes one cycle after it is accepted. An indirect access spends one extra cycle waiting for the synchronous memory read.

Top module: `paged_ea_unit`

## Requirements
- R1: After reset `done`, `busy`, `mem_rd` and `op_addr` are 0, and both field registers are 0. A first direct access therefore yields field 0.
- R2: Instruction bits are decoded as follows: bit 8 is indirect, bit 7 is the page bit and bits 6..0 are the offset. For a direct access with page bit 0, `done` pulses in the cycle after `start` is accepted, and `op_addr` = {instruction field, 5'b0, offset}. No memory read is issued.
- R3: For a direct access with page bit 1, `op_addr` = {instruction field, pc[11:7], offset}.
- R4: For an indirect access, `mem_rd` is high in the accepting cycle, and `mem_addr` = {instruction field, directly formed 12-bit address}. The memory returns its word one cycle later. `done` then pulses two cycles after acceptance, with `op_addr` = {data field, returned word}.
- R5: When `wr_df` is high at a clock edge, the data field loads `fld_num`. When `wr_if` is high, the instruction field loads `fld_num`. Both may load in the same cycle.
- R6: An access uses the field values in force in the cycle `start` is accepted. A field write in that same cycle affects only later accesses.
- R7: While `busy` is high, `start` is ignored. The pending indirect access still completes, and no second `done` follows.
- R8: Instruction bits 11..9 have no effect on any output.
- R9: `done` is a one-cycle pulse. `op_addr` holds its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an address for `instr` |
| instr | input | 12 | Memory-reference instruction word |
| pc | input | 12 | Current program counter within the instruction field |
| fld_num | input | 3 | Field number for a field-select command |
| wr_df | input | 1 | Load `fld_num` into the data field |
| wr_if | input | 1 | Load `fld_num` into the instruction field |
| mem_rd | output | 1 | Pointer read request |
| mem_addr | output | 15 | Pointer read address {field, word} |
| mem_rdata | input | 12 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Indirect fetch outstanding; `start` ignored |
| done | output | 1 | `op_addr` is valid this cycle |
| op_addr | output | 15 | Operand address {field, word} |

## Verification
Each result has its own due cycle, counted from the cycle in which `start` is accepted:
- `mem_rd` and `mem_addr` are combinational, so they are due in that same cycle.
- A direct result is due one cycle later.
- An indirect result is due two cycles later, because the bench memory answers one cycle after the request.

The bench drives inputs on the falling edge. It checks the combinational read request shortly after driving. It checks registered outputs at the next falling edge or the one after, matching these counts. One idle cycle is then checked for a low `done` and an unchanged `op_addr`.

// File: rtl/paged_ea_unit.sv
module paged_ea_unit #(
  parameter int OFS_W  = 7,
  parameter int WORD_W = 12,
  parameter int FLD_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [WORD_W-1:0]       instr,
  input  logic [WORD_W-1:0]       pc,
  input  logic [FLD_W-1:0]        fld_num,
  input  logic                    wr_df,
  input  logic                    wr_if,
  output logic                    mem_rd,
  output logic [FLD_W+WORD_W-1:0] mem_addr,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    busy,
  output logic                    done,
  output logic [FLD_W+WORD_W-1:0] op_addr
);
  localparam int PAGE_W = WORD_W - OFS_W;
  localparam int IND_B  = OFS_W + 1;
  localparam int PG_B   = OFS_W;

  logic [FLD_W-1:0]        ifld, dfld, df_hold;
  logic                    busy_q, done_q;
  logic [FLD_W+WORD_W-1:0] op_q;

  wire ind    = instr[IND_B];
  wire pg     = instr[PG_B];
  wire accept = start & ~busy_q;
  wire [PAGE_W-1:0] page   = pg ? pc[WORD_W-1:OFS_W] : {PAGE_W{1'b0}};
  wire [WORD_W-1:0] direct = {page, instr[OFS_W-1:0]};

  assign mem_rd   = accept & ind;
  assign mem_addr = {ifld, direct};
  assign busy     = busy_q;
  assign done     = done_q;
  assign op_addr  = op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifld    <= '0;
      dfld    <= '0;
      df_hold <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (wr_df) dfld <= fld_num;
      if (wr_if) ifld <= fld_num;
      if (busy_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        op_q   <= {df_hold, mem_rdata};
      end else if (accept) begin
        if (ind) begin
          busy_q  <= 1'b1;
          df_hold <= dfld;
        end else begin
          done_q <= 1'b1;
          op_q   <= {ifld, direct};
        end
      end
    end
  end

  assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !instr[IND_B]) |=> (done &&
      op_addr[OFS_W-1:0] == $past(instr[OFS_W-1:0]) &&
      op_addr[WORD_W-1:OFS_W] == ($past(instr[PG_B]) ? $past(pc[WORD_W-1:OFS_W]) : {PAGE_W{1'b0}})));

  assert_read_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (start && !busy && instr[IND_B]));

  assert_fetch_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (busy && !done));

  assert_one_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && done));

  assert_df_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_df |=> (dfld == $past(fld_num)));

  assert_if_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_if |=> (ifld == $past(fld_num)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(op_addr));
endmodule

// File: tb/paged_ea_unit_test.sv
`timescale 1ns/1ps
module paged_ea_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] pc = '0;
  logic [2:0]  fld_num = '0;
  logic        wr_df = 1'b0;
  logic        wr_if = 1'b0;
  logic        mem_rd;
  logic [14:0] mem_addr;
  logic [11:0] mem_rdata = '0;
  logic        busy, done;
  logic [14:0] op_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  paged_ea_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
    .fld_num(fld_num), .wr_df(wr_df), .wr_if(wr_if),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .op_addr(op_addr)
  );

  function automatic logic [11:0] mem_word(input logic [14:0] a);
    return a[11:0] ^ 12'hA53 ^ {a[14:12], a[14:12], 6'b0};
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem_word(mem_addr);

  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {3'd0, 3'd0, 12'h3C4, 12'h015},
    {3'd2, 3'd5, 12'hABC, 12'h2FF},
    {3'd1, 3'd6, 12'hFFF, 12'hB00},
    {3'd7, 3'd3, 12'h800, 12'hFAA},
    {3'd4, 3'd4, 12'h07F, 12'h680},
    {3'd0, 3'd7, 12'h123, 12'h57F},
    {3'd3, 3'd1, 12'hF80, 12'hCD5},
    {3'd5, 3'd0, 12'h5A5, 12'h981}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] direct_of(input logic [11:0] i, input logic [11:0] p);
    return {i[7] ? p[11:7] : 5'b0, i[6:0]};
  endfunction

  task automatic set_fields(input logic [2:0] f_if, input logic [2:0] f_df);
    @(negedge clk); wr_if = 1'b1; fld_num = f_if;
    @(negedge clk); wr_if = 1'b0; wr_df = 1'b1; fld_num = f_df;
    @(negedge clk); wr_df = 1'b0;
  endtask

  task automatic access(input logic [11:0] i, input logic [11:0] p,
                        input logic [2:0] f_if, input logic [2:0] f_df, input string req);
    logic [11:0] d;
    logic [14:0] exp_a;
    logic [14:0] held;
    d = direct_of(i, p);
    @(negedge clk); start = 1'b1; instr = i; pc = p;
    #1;
    chk(mem_rd == i[8], {req, " R4 mem_rd"}, mem_rd, i[8]);
    if (i[8]) chk(mem_addr == {f_if, d}, {req, " R4 mem_addr"}, mem_addr, {f_if, d});
    @(negedge clk); start = 1'b0;
    if (!i[8]) begin
      exp_a = {f_if, d};
      chk(done === 1'b1 && op_addr == exp_a, {req, " R2/R3 direct"}, {done, op_addr}, {1'b1, exp_a});
    end else begin
      chk(done === 1'b0 && busy === 1'b1, {req, " R4 wait"}, {done, busy}, 2'b01);
      @(negedge clk);
      exp_a = {f_df, mem_word({f_if, d})};
      chk(done === 1'b1 && op_addr == exp_a, {req, " R4 indirect"}, {done, op_addr}, {1'b1, exp_a});
    end
    held = op_addr;
    @(negedge clk);
    chk(done === 1'b0 && op_addr == held, {req, " R9 pulse/hold"}, {done, op_addr}, {1'b0, held});
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(done === 1'b0 && busy === 1'b0 && mem_rd === 1'b0 && op_addr == 15'd0,
        "R1 reset outputs", {done, busy, mem_rd, op_addr}, 18'd0);
    access(12'h0A5, 12'hFFF, 3'd0, 3'd0, "R1 reset fields R3");

    for (int k = 0; k < NV; k++) begin
      set_fields(VEC[k][29:27], VEC[k][26:24]);
      access(VEC[k][11:0], VEC[k][23:12], VEC[k][29:27], VEC[k][26:24], "R5 table");
    end

    // R8: only the opcode bits differ, so every output must match.
    set_fields(3'd6, 3'd2);
    access(12'h02A, 12'h777, 3'd6, 3'd2, "R8 op0");
    access(12'hE2A, 12'h777, 3'd6, 3'd2, "R8 op7");
    access(12'h1AA, 12'h777, 3'd6, 3'd2, "R8 op0 ind");
    access(12'hFAA, 12'h777, 3'd6, 3'd2, "R8 op7 ind");

    // R5: load both fields in a single cycle.
    @(negedge clk); wr_if = 1'b1; wr_df = 1'b1; fld_num = 3'd5;
    @(negedge clk); wr_if = 1'b0; wr_df = 1'b0;
    access(12'h1C3, 12'h400, 3'd5, 3'd5, "R5 both");

    // R6: a field write in the same cycle as start does not affect that access.
    set_fields(3'd1, 3'd2);
    @(negedge clk); start = 1'b1; instr = 12'h110; pc = 12'h000;
    wr_df = 1'b1; wr_if = 1'b1; fld_num = 3'd6;
    #1;
    chk(mem_addr == {3'd1, 12'h010}, "R6 same-cycle IF", mem_addr, {3'd1, 12'h010});
    @(negedge clk); start = 1'b0; wr_df = 1'b0; wr_if = 1'b0;
    @(negedge clk);
    chk(done === 1'b1 && op_addr == {3'd2, mem_word({3'd1, 12'h010})}, "R6 same-cycle DF",
        op_addr, {3'd2, mem_word({3'd1, 12'h010})});
    @(negedge clk);
    access(12'h110, 12'h000, 3'd6, 3'd6, "R6 later access");

    // R7: start while busy is ignored.
    @(negedge clk); start = 1'b1; instr = 12'h133; pc = 12'h000;
    @(negedge clk); instr = 12'h044;
    chk(busy === 1'b1 && done === 1'b0, "R7 busy", {busy, done}, 2'b10);
    @(negedge clk); start = 1'b0;
    chk(done === 1'b1 && op_addr == {3'd6, mem_word({3'd6, 12'h033})}, "R7 pending completes",
        op_addr, {3'd6, mem_word({3'd6, 12'h033})});
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R7 no second done", {done, busy}, 2'b00);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule